// File: doc/BRIEF.md
# Asynchronous Character Transmitter with Break Control

The block turns buffered characters into an asynchronous serial stream. A one-character holding register accepts a write from the host side. When the serial engine is free, it takes the character over into a frame register. A frame is one low start bit, then 5 to 8 data bits (least significant first), then an optional parity bit, then an optional address/ninth bit, then one or two high stop bits. Each bit lasts one bit period. A bit period is the interval between two pulses of the `bit_tick` strobe, which an external rate generator supplies.

The address/ninth bit comes from a one-bit mark flag. The host sets this flag with `addr_set`. The hardware copies it into the frame when a character is taken over and clears it in the same step. The parity covers only the data bits. A level request, `brk_req`, asks for a break. The break waits until both the holding register and the engine are empty. It then holds the line low for at least one full frame of the current format, and longer while the request stays high. It ends with exactly one high bit period, after which a new character may start.

Top module: `txs_serial_tx`

## Requirements
- R1: After reset `tx_line` is 1, `buf_empty` is 1, `shift_empty` is 1 and `addr_pend` is 0. With no work pending, the line stays 1 at every bit period.
- R2: A frame is a start bit 0, then N data bits least significant first, where N = 5 + `cfg_wlen` (code 0..3 gives 5..8), then one stop bit 1, or two when `cfg_two_stop` is 1. Each bit lasts one bit period. The line changes on the clock edge that samples `bit_tick` high.
- R3: When `cfg_par_en` is 1, a parity bit follows the data bits. It covers only the N transmitted data bits. With `cfg_par_even` = 1 the data plus parity hold an even number of ones; with 0, an odd number.
- R4: When `cfg_nine_en` is 1, the mark bit follows the parity bit (or the last data bit when parity is off) and comes just before the first stop bit. Its value is `addr_pend` at the moment the character is taken over, and it never enters the parity.
- R5: A pulse on `addr_set` makes `addr_pend` 1 one cycle later. Taking a character over into the engine clears `addr_pend`.
- R6: A write while `buf_empty` is 1 is captured, and `buf_empty` reads 0 one cycle later. A write while `buf_empty` is 0 is ignored: the held character is transmitted unchanged.
- R7: A held character is taken over on the tick that ends the last stop bit of the current frame, so no idle period appears between the two frames. `buf_empty` reads 1 from the cycle after that tick.
- R8: `shift_empty` is 1 exactly when the engine is idle (not sending a frame and not in a break) and no character is held.
- R9: A break request that arrives while a character is held or being sent takes effect only after that character's last stop bit. It then starts with no idle period.
- R10: A break holds the line at 0 for max(L, H) bit periods. L is the frame length of the format in force when the break starts. H is the number of ticks at which `brk_req` is still 1, counting from the tick that starts the break.
- R11: A break ends with the line at 1 for exactly one bit period. A character that is held by then starts on the very next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe marking each bit-period boundary |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to write |
| addr_set | input | 1 | Pulse that sets the mark flag |
| brk_req | input | 1 | Break request (level) |
| cfg_wlen | input | 2 | Data length code: 5 + code bits |
| cfg_par_en | input | 1 | Insert a parity bit |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_nine_en | input | 1 | Insert the mark (address/ninth) bit |
| cfg_two_stop | input | 1 | 1 gives two stop bits |
| tx_line | output | 1 | Serial output, idle high |
| buf_empty | output | 1 | Holding register is empty |
| shift_empty | output | 1 | Engine idle and nothing held |
| addr_pend | output | 1 | Mark flag awaiting take-over |

## Verification
The line reaches its new level on the clock edge where `bit_tick` is sampled high. The bench therefore compares the line once per bit period, in the half cycle before the next tick edge. It checks each bit against a stream of expected bits that it builds from the configuration, the data and the mark value. `buf_empty` and `addr_pend` respond one clock after a write or an `addr_set` pulse, and they are read on the following falling edge. A take-over happens on a tick edge, and is confirmed on the next falling edge by the fall of `addr_pend`, the rise of `buf_empty`, and the number of expected bits still pending. Break length and the single high terminator are checked as part of the same bit stream, so an extra or missing period shows up as a mismatch on the next sample.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int DATA_W    = 8;
  localparam int MIN_WORD  = 5;
  localparam int MAX_STOP  = 2;
  localparam int FRAME_W   = 1 + DATA_W + 1 + 1 + MAX_STOP;
  localparam int LEN_W     = $clog2(FRAME_W + 1);
  localparam int WCODE_W   = $clog2(DATA_W - MIN_WORD + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_BRKLO = 2'd2,
    ST_BRKHI = 2'd3
  } eng_state_e;

  typedef struct packed {
    logic [WCODE_W-1:0] wlen;
    logic               par_en;
    logic               par_even;
    logic               nine_en;
    logic               two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/txs_framer.sv
module txs_framer
  import txs_pkg::*;
(
  input  frame_cfg_t        cfg,
  input  logic [DATA_W-1:0] data,
  input  logic              mark_bit,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   frame_len
);
  logic [LEN_W-1:0]  word_len;
  logic [DATA_W-1:0] masked;
  logic              par_bit;
  logic [LEN_W-1:0]  pos;

  // keep only the bits that go on the line
  always_comb begin
    word_len = LEN_W'(MIN_WORD) + LEN_W'(cfg.wlen);
    for (int i = 0; i < DATA_W; i++) begin
      masked[i] = (i < int'(word_len)) ? data[i] : 1'b0;
    end
    par_bit = cfg.par_even ? (^masked) : ~(^masked);
  end

  // lay the frame out from bit 0 upward; unused tail stays high (stop level)
  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(word_len)) frame[i+1] = data[i];
    end
    pos = word_len + LEN_W'(1);
    if (cfg.par_en) begin
      frame[pos] = par_bit;
      pos        = pos + LEN_W'(1);
    end
    if (cfg.nine_en) begin
      frame[pos] = mark_bit;
      pos        = pos + LEN_W'(1);
    end
    frame_len = pos + LEN_W'(1) + LEN_W'(cfg.two_stop);
  end
endmodule

// File: rtl/txs_holdreg.sv
module txs_holdreg
  import txs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              addr_set,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full,
  output logic              mark_q
);
  logic [DATA_W-1:0] data_q, data_n;
  logic              full_q, full_n;
  logic              mark_n;
  logic              accept;

  always_comb begin
    accept = wr_en & ~full_q;
    full_n = accept | (full_q & ~take);
    data_n = accept ? wr_data : data_q;
    mark_n = addr_set | (mark_q & ~take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      data_q <= data_n;
      full_q <= full_n;
      mark_q <= mark_n;
    end
  end

  assign hold_data = data_q;
  assign hold_full = full_q;

  // R6
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !full_q |=> full_q);
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !take |=> full_q && $stable(data_q));
  // R5
  mark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !addr_set |=> !mark_q);
endmodule

// File: rtl/txs_engine.sv
module txs_engine
  import txs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               hold_full,
  input  logic               brk_req,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   frame_len,
  output logic               take,
  output logic               line,
  output logic               idle
);
  eng_state_e         state_q, state_n;
  logic [FRAME_W-1:0] shreg_q, shreg_n;
  logic [LEN_W-1:0]   cnt_q, cnt_n;
  logic [LEN_W-1:0]   len_q, len_n;
  logic               line_q, line_n;
  logic               decide;
  logic               last_bit;

  assign last_bit = (cnt_q == len_q - LEN_W'(1));

  always_comb begin
    state_n = state_q;
    shreg_n = shreg_q;
    cnt_n   = cnt_q;
    len_n   = len_q;
    line_n  = line_q;
    take    = 1'b0;
    decide  = 1'b0;
    if (tick) begin
      unique case (state_q)
        ST_IDLE, ST_BRKHI: decide = 1'b1;
        ST_SHIFT: begin
          if (last_bit) begin
            decide = 1'b1;
          end else begin
            cnt_n  = cnt_q + LEN_W'(1);
            line_n = shreg_q[cnt_q + LEN_W'(1)];
          end
        end
        ST_BRKLO: begin
          if (last_bit) begin
            if (!brk_req) begin
              state_n = ST_BRKHI;
              line_n  = 1'b1;
            end
          end else begin
            cnt_n = cnt_q + LEN_W'(1);
          end
        end
        default: decide = 1'b1;
      endcase
    end
    if (decide) begin
      if (hold_full) begin
        take    = 1'b1;
        state_n = ST_SHIFT;
        shreg_n = frame;
        len_n   = frame_len;
        cnt_n   = '0;
        line_n  = frame[0];
      end else if (brk_req) begin
        state_n = ST_BRKLO;
        len_n   = frame_len;
        cnt_n   = '0;
        line_n  = 1'b0;
      end else begin
        state_n = ST_IDLE;
        line_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '1;
      cnt_q   <= '0;
      len_q   <= LEN_W'(1);
      line_q  <= 1'b1;
    end else begin
      state_q <= state_n;
      shreg_q <= shreg_n;
      cnt_q   <= cnt_n;
      len_q   <= len_n;
      line_q  <= line_n;
    end
  end

  assign line = line_q;
  assign idle = (state_q == ST_IDLE);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE |-> line_q);
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_SHIFT |-> cnt_q < len_q);
  // R10
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_BRKLO |-> !line_q);
  // R11
  brk_term_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_BRKHI |-> line_q);
  // R11
  brk_term_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_BRKHI && tick |=> state_q != ST_BRKHI);
endmodule

// File: rtl/txs_serial_tx.sv
module txs_serial_tx
  import txs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              addr_set,
  input  logic              brk_req,
  input  logic [WCODE_W-1:0] cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_nine_en,
  input  logic              cfg_two_stop,
  output logic              tx_line,
  output logic              buf_empty,
  output logic              shift_empty,
  output logic              addr_pend
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;
  frame_cfg_t             cfg;
  logic [DATA_W-1:0]      hold_data;
  logic                   hold_full;
  logic                   mark_q;
  logic                   take;
  logic                   eng_idle;
  logic [FRAME_W-1:0]     frame;
  logic [LEN_W-1:0]       frame_len;

  // reset asserts at once, leaves on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  always_comb begin
    cfg.wlen     = cfg_wlen;
    cfg.par_en   = cfg_par_en;
    cfg.par_even = cfg_par_even;
    cfg.nine_en  = cfg_nine_en;
    cfg.two_stop = cfg_two_stop;
  end

  txs_holdreg u_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .addr_set  (addr_set),
    .take      (take),
    .hold_data (hold_data),
    .hold_full (hold_full),
    .mark_q    (mark_q)
  );

  txs_framer u_framer (
    .cfg       (cfg),
    .data      (hold_data),
    .mark_bit  (mark_q),
    .frame     (frame),
    .frame_len (frame_len)
  );

  txs_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (bit_tick),
    .hold_full (hold_full),
    .brk_req   (brk_req),
    .frame     (frame),
    .frame_len (frame_len),
    .take      (take),
    .line      (tx_line),
    .idle      (eng_idle)
  );

  assign buf_empty   = ~hold_full;
  assign shift_empty = eng_idle & ~hold_full;
  assign addr_pend   = mark_q;

  // R8
  shift_empty_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    shift_empty |-> buf_empty && tx_line);
  // R7
  take_empties_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take && !wr_en |=> buf_empty);
endmodule

// File: tb/txs_serial_tx_tb.sv
module txs_serial_tx_tb;
  localparam int TICK_DIV = 4;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       addr_set = 1'b0;
  logic       brk_req = 1'b0;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_nine_en = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       tx_line, buf_empty, shift_empty, addr_pend;

  int checks = 0;
  int errors = 0;
  int tcnt = 0;
  bit mon_on = 1'b0;
  bit exp_q[$];
  string tag_q[$];

  txs_serial_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_data(wr_data), .addr_set(addr_set), .brk_req(brk_req),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_nine_en(cfg_nine_en), .cfg_two_stop(cfg_two_stop),
    .tx_line(tx_line), .buf_empty(buf_empty), .shift_empty(shift_empty),
    .addr_pend(addr_pend)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // tick generator and line monitor share one process: sample before the tick edge
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % TICK_DIV;
    if (tcnt == 0) begin
      bit_tick = 1'b1;
      if (mon_on) begin
        bit e;
        string t;
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
        end else begin
          e = 1'b1;
          t = "R1";
        end
        check(tx_line == e, t, "line bit", int'(tx_line), int'(e));
      end
    end else begin
      bit_tick = 1'b0;
    end
  end

  task automatic push_bit(input bit b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  function automatic int frame_len_f();
    return 1 + 5 + int'(cfg_wlen) + int'(cfg_par_en) + int'(cfg_nine_en) + 1 + int'(cfg_two_stop);
  endfunction

  task automatic push_frame(input logic [7:0] d, input bit mark);
    int n;
    int ones;
    n = 5 + int'(cfg_wlen);
    ones = 0;
    push_bit(1'b0, "R2");
    for (int i = 0; i < n; i++) begin
      push_bit(d[i], "R2");
      if (d[i]) ones++;
    end
    if (cfg_par_en) push_bit(cfg_par_even ? bit'(ones % 2) : bit'(1 - ones % 2), "R3");
    if (cfg_nine_en) push_bit(mark, "R4");
    push_bit(1'b1, "R2");
    if (cfg_two_stop) push_bit(1'b1, "R2");
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!bit_tick);
    @(negedge clk);
  endtask

  task automatic write_char(input logic [7:0] d);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_mark();
    addr_set = 1'b1;
    @(negedge clk);
    addr_set = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    wait_tick();
    wait_tick();
  endtask

  task automatic set_cfg(input logic [1:0] wl, input bit pe, input bit ev,
                         input bit ne, input bit ts);
    cfg_wlen = wl; cfg_par_en = pe; cfg_par_even = ev;
    cfg_nine_en = ne; cfg_two_stop = ts;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    int L;
    seed = $urandom(32'd24681);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(tx_line == 1'b1, "R1", "tx_line after reset", int'(tx_line), 1);
    check(buf_empty == 1'b1, "R1", "buf_empty after reset", int'(buf_empty), 1);
    check(shift_empty == 1'b1, "R1", "shift_empty after reset", int'(shift_empty), 1);
    check(addr_pend == 1'b0, "R1", "addr_pend after reset", int'(addr_pend), 0);
    mon_on = 1'b1;
    wait_tick();

    // R3 R4 R5 R6 R8: even parity, mark bit set, write while full ignored
    set_cfg(2'd3, 1'b1, 1'b1, 1'b1, 1'b0);
    pulse_mark();
    check(addr_pend == 1'b1, "R5", "addr_pend after set", int'(addr_pend), 1);
    wait_tick();
    push_bit(1'b1, "R1");
    push_frame(8'hA5, 1'b1);
    write_char(8'hA5);
    check(buf_empty == 1'b0, "R6", "buf_empty after write", int'(buf_empty), 0);
    check(shift_empty == 1'b0, "R8", "shift_empty with char held", int'(shift_empty), 0);
    write_char(8'h3C);
    while (!buf_empty) @(negedge clk);
    check(addr_pend == 1'b0, "R5", "addr_pend after take-over", int'(addr_pend), 0);
    check(shift_empty == 1'b0, "R8", "shift_empty while sending", int'(shift_empty), 0);
    drain();
    check(shift_empty == 1'b1, "R8", "shift_empty after drain", int'(shift_empty), 1);

    // R3: odd parity, 5 bits, upper bits excluded, two stops
    set_cfg(2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    wait_tick();
    push_bit(1'b1, "R1");
    push_frame(8'hFF, 1'b0);
    write_char(8'hFF);
    drain();

    // R7: back-to-back, mark only on the first
    set_cfg(2'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    pulse_mark();
    wait_tick();
    push_bit(1'b1, "R1");
    push_frame(8'h4B, 1'b1);
    write_char(8'h4B);
    while (!buf_empty) @(negedge clk);
    push_frame(8'h12, 1'b0);
    L = frame_len_f();
    write_char(8'h12);
    while (!buf_empty) @(negedge clk);
    check(exp_q.size() == L, "R7", "bits left at second take-over", exp_q.size(), L);
    drain();

    // R10 R11: minimum break from idle, char written during break
    set_cfg(2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    L = frame_len_f();
    wait_tick();
    brk_req = 1'b1;
    push_bit(1'b1, "R1");
    for (int i = 0; i < L; i++) push_bit(1'b0, "R10");
    push_bit(1'b1, "R11");
    push_frame(8'h2D, 1'b0);
    wait_tick();
    wait_tick();
    brk_req = 1'b0;
    write_char(8'h2D);
    check(shift_empty == 1'b0, "R8", "shift_empty in break", int'(shift_empty), 0);
    drain();

    // R10: extended break
    set_cfg(2'd3, 1'b0, 1'b0, 1'b1, 1'b1);
    L = frame_len_f();
    wait_tick();
    brk_req = 1'b1;
    push_bit(1'b1, "R1");
    for (int i = 0; i < L + 3; i++) push_bit(1'b0, "R10");
    push_bit(1'b1, "R11");
    for (int i = 0; i < L + 3; i++) wait_tick();
    brk_req = 1'b0;
    drain();

    // R9: break requested with a char held waits for its frame
    set_cfg(2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    L = frame_len_f();
    wait_tick();
    brk_req = 1'b1;
    push_bit(1'b1, "R1");
    push_frame(8'h66, 1'b0);
    for (int i = 0; i < L; i++) push_bit(1'b0, "R9");
    push_bit(1'b1, "R11");
    write_char(8'h66);
    for (int i = 0; i < L + 2; i++) wait_tick();
    brk_req = 1'b0;
    drain();

    // random frames, single and paired
    for (int it = 0; it < 40; it++) begin
      logic [7:0] d0, d1;
      bit m0, pair;
      set_cfg(2'($urandom_range(3)), 1'($urandom_range(1)), 1'($urandom_range(1)),
              1'($urandom_range(1)), 1'($urandom_range(1)));
      d0 = 8'($urandom_range(255));
      d1 = 8'($urandom_range(255));
      m0 = 1'($urandom_range(1));
      pair = 1'($urandom_range(1));
      if (m0) pulse_mark();
      wait_tick();
      push_bit(1'b1, "R1");
      push_frame(d0, m0);
      write_char(d0);
      if (pair) begin
        while (!buf_empty) @(negedge clk);
        push_frame(d1, 1'b0);
        write_char(d1);
      end
      drain();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule